// File: doc/BRIEF.md
# SPDIF Transmit Sample Formatter

This block sits between the transmit data FIFO of a digital audio output and the biphase line coder. Each time the coder wants the next subframe, it accepts one subframe from this block. The subframe carries a 24-bit audio field, the validity, user, channel-status and parity bits, a 4-bit preamble code and a marker that says whether the subframe belongs to the left or the right channel. The formatter decodes the FIFO word according to the selected sample format. It also decides when a FIFO word has been used up and may be popped.

A 2-bit format selector picks 16-bit, 20-bit, 24-bit or raw words. A packing enable folds two 16-bit samples into one word. In raw mode, software builds every subframe field itself, and the block passes those fields through unchanged. In the other modes the block supplies the user and channel-status bits from two side inputs. In those modes it clears the validity bit, computes parity and generates the preamble from its own frame count. When the coder asks for a subframe and the FIFO is empty, the block sends a silent subframe and flags an underrun for that cycle.

Top module: `spdif_txfmt`

## Requirements
- R1: While `rstN` is low, `subValid`, `wordReady` and `underrun` are 0. From the first clock edge after reset, `subValid` stays 1. The first subframe after reset is a left subframe with the block-start preamble 4'b0001.
- R2: In mode 2'b00 with packing off, `subAudio` = {word[15:0], 8'h00}. One word is popped per accepted subframe.
- R3: In mode 2'b01, `subAudio` = {word[19:0], 4'h0}.
- R4: In mode 2'b10, `subAudio` = word[23:0]. Word bits 31:24 have no effect on the audio field.
- R5: In mode 2'b11 (raw), `subP`/`subC`/`subU`/`subV` come from word bits 31/30/29/28 and `subAudio` = word[27:4] (data in 23:4, aux in 3:0). `subPreamble` comes from word[3:0]. Parity is passed through, not recomputed.
- R6: In mode 2'b00 with `packEn` = 1, the left subframe carries {word[15:0], 8'h00} without popping. The following right subframe carries {word[31:16], 8'h00} and pops the word.
- R7: `packEn` has no effect in modes 2'b01, 2'b10 and 2'b11: every accepted subframe pops one word.
- R8: Outside raw mode, `subV` = 0, `subU` = `usrBit` and `subC` = `chanBit`. `subP` makes the count of ones over audio, V, U, C and P even.
- R9: Accepted subframes alternate left, right, left, and so on. Outside raw mode, the preamble is 4'b0001 on the left subframe of the first frame of every block of `FRAMES_PER_BLOCK` frames. It is 4'b0010 on every other left subframe and 4'b0100 on every right subframe.
- R10: If `subReady` = 1 while `wordValid` = 0, `underrun` is 1 in that cycle. The subframe has zero audio, V = 0, U/C from the side inputs, computed parity and the generated preamble. The side still advances, and the pop is not counted.
- R11: While `subReady` = 0, `wordReady` and `underrun` stay 0, and the side and frame position hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sampleMode | input | 2 | 00 16-bit, 01 20-bit, 10 24-bit, 11 raw |
| packEn | input | 1 | Two 16-bit samples per word (effective in mode 00 only) |
| usrBit | input | 1 | User bit for non-raw subframes |
| chanBit | input | 1 | Channel-status bit for non-raw subframes |
| wordValid | input | 1 | FIFO word present |
| wordReady | output | 1 | Pop strobe for the FIFO word |
| wordData | input | 32 | FIFO word |
| subValid | output | 1 | Subframe available |
| subReady | input | 1 | Coder takes the subframe this cycle |
| subAudio | output | 24 | Audio field, MSB-aligned |
| subV | output | 1 | Validity bit |
| subU | output | 1 | User bit |
| subC | output | 1 | Channel-status bit |
| subP | output | 1 | Parity bit |
| subPreamble | output | 4 | Preamble code |
| subLeft | output | 1 | 1 on left subframes |
| underrun | output | 1 | Subframe sent with no word available |

## Verification
The hardest case to reach is a packed word whose left half falls into an underrun. The word then arrives in the middle of the frame, and the right half has to be taken from it and the word popped. The stimulus sweeps every mode and packing combination. It lowers `wordValid` and `subReady` on independent cycle patterns, so underruns land on both sides of packed frames and across block boundaries. The bench uses a small `FRAMES_PER_BLOCK`, so block-start preambles recur many times in the sweep.

// File: rtl/spdif_txfmt_pkg.sv
package spdif_txfmt_pkg;
  localparam int WORD_W  = 32;
  localparam int AUDIO_W = 24;
  localparam int PRE_W   = 4;

  typedef enum logic [1:0] {
    MODE_16  = 2'b00,
    MODE_20  = 2'b01,
    MODE_24  = 2'b10,
    MODE_RAW = 2'b11
  } sampleMode_e;

  localparam logic [PRE_W-1:0] PRE_BLOCK = 4'b0001;
  localparam logic [PRE_W-1:0] PRE_LEFT  = 4'b0010;
  localparam logic [PRE_W-1:0] PRE_RIGHT = 4'b0100;

  // strobes from control to datapath
  typedef struct packed {
    logic useWord;     // a FIFO word feeds this subframe
    logic takeHigh;    // packed right half
    logic isLeft;
    logic blockStart;
  } fmtCtrl_t;
endpackage

// File: rtl/spdif_txfmt_ctrl.sv
module spdif_txfmt_ctrl
  import spdif_txfmt_pkg::*;
#(
  parameter int FRAMES_PER_BLOCK = 192
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] modeIn,
  input  logic       packEn,
  input  logic       wordValid,
  input  logic       subReady,
  output logic       subValid,
  output logic       wordReady,
  output logic       underrun,
  output fmtCtrl_t   ctrlOut
);
  localparam int CNT_W = (FRAMES_PER_BLOCK > 2) ? $clog2(FRAMES_PER_BLOCK) : 1;
  localparam logic [CNT_W-1:0] LAST_FRAME = CNT_W'(FRAMES_PER_BLOCK - 1);

  logic             active;
  logic             sideLeft;
  logic [CNT_W-1:0] frameCnt;
  logic             packActive;
  logic             xfer;

  assign packActive = packEn && (sampleMode_e'(modeIn) == MODE_16);
  assign xfer       = active && subReady;
  assign subValid   = active;
  assign wordReady  = xfer && !(packActive && sideLeft);
  assign underrun   = xfer && !wordValid;

  always_comb begin
    ctrlOut.useWord    = wordValid;
    ctrlOut.takeHigh   = packActive && !sideLeft;
    ctrlOut.isLeft     = sideLeft;
    ctrlOut.blockStart = sideLeft && (frameCnt == '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active   <= 1'b0;
      sideLeft <= 1'b1;
      frameCnt <= '0;
    end else begin
      active <= 1'b1;
      if (xfer) begin
        sideLeft <= !sideLeft;
        if (!sideLeft)
          frameCnt <= (frameCnt == LAST_FRAME) ? '0 : frameCnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spdif_txfmt_dp.sv
module spdif_txfmt_dp
  import spdif_txfmt_pkg::*;
(
  input  logic [WORD_W-1:0]  wordData,
  input  logic [1:0]         modeIn,
  input  logic               usrBit,
  input  logic               chanBit,
  input  fmtCtrl_t           ctrlIn,
  output logic [AUDIO_W-1:0] audioOut,
  output logic               vOut,
  output logic               uOut,
  output logic               cOut,
  output logic               pOut,
  output logic [PRE_W-1:0]   preOut
);
  logic [PRE_W-1:0] preGen;
  logic [15:0]      half16;
  logic             isRaw;

  assign preGen = ctrlIn.blockStart ? PRE_BLOCK : (ctrlIn.isLeft ? PRE_LEFT : PRE_RIGHT);
  assign half16 = ctrlIn.takeHigh ? wordData[31:16] : wordData[15:0];
  assign isRaw  = (sampleMode_e'(modeIn) == MODE_RAW) && ctrlIn.useWord;

  always_comb begin
    unique case (sampleMode_e'(modeIn))
      MODE_16:  audioOut = {half16, 8'h00};
      MODE_20:  audioOut = {wordData[19:0], 4'h0};
      MODE_24:  audioOut = wordData[23:0];
      default:  audioOut = wordData[27:4];
    endcase
    if (!ctrlIn.useWord) audioOut = '0;

    if (isRaw) begin
      vOut   = wordData[28];
      uOut   = wordData[29];
      cOut   = wordData[30];
      pOut   = wordData[31];
      preOut = wordData[3:0];
    end else begin
      vOut   = 1'b0;
      uOut   = usrBit;
      cOut   = chanBit;
      preOut = preGen;
      pOut   = ^{audioOut, 1'b0, usrBit, chanBit};
    end
  end
endmodule

// File: rtl/spdif_txfmt.sv
module spdif_txfmt
  import spdif_txfmt_pkg::*;
#(
  parameter int FRAMES_PER_BLOCK = 192
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  sampleMode,
  input  logic        packEn,
  input  logic        usrBit,
  input  logic        chanBit,
  input  logic        wordValid,
  output logic        wordReady,
  input  logic [31:0] wordData,
  output logic        subValid,
  input  logic        subReady,
  output logic [23:0] subAudio,
  output logic        subV,
  output logic        subU,
  output logic        subC,
  output logic        subP,
  output logic [3:0]  subPreamble,
  output logic        subLeft,
  output logic        underrun
);
  fmtCtrl_t fmtCtrl;

  spdif_txfmt_ctrl #(.FRAMES_PER_BLOCK(FRAMES_PER_BLOCK)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .modeIn    (sampleMode),
    .packEn    (packEn),
    .wordValid (wordValid),
    .subReady  (subReady),
    .subValid  (subValid),
    .wordReady (wordReady),
    .underrun  (underrun),
    .ctrlOut   (fmtCtrl)
  );

  spdif_txfmt_dp u_dp (
    .wordData (wordData),
    .modeIn   (sampleMode),
    .usrBit   (usrBit),
    .chanBit  (chanBit),
    .ctrlIn   (fmtCtrl),
    .audioOut (subAudio),
    .vOut     (subV),
    .uOut     (subU),
    .cOut     (subC),
    .pOut     (subP),
    .preOut   (subPreamble)
  );

  assign subLeft = fmtCtrl.isLeft;
endmodule

// File: rtl/spdif_txfmt_chk.sv
module spdif_txfmt_chk (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  sampleMode,
  input logic        packEn,
  input logic        usrBit,
  input logic        chanBit,
  input logic        wordValid,
  input logic        wordReady,
  input logic [31:0] wordData,
  input logic        subValid,
  input logic        subReady,
  input logic [23:0] subAudio,
  input logic        subV,
  input logic        subU,
  input logic        subC,
  input logic        subP,
  input logic [3:0]  subPreamble,
  input logic        subLeft,
  input logic        underrun
);
  p_idle_no_pop_r11: assert property (@(posedge clk) disable iff (!rstN)
    !subReady |-> (!wordReady && !underrun));

  p_idle_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (subValid && !subReady) |=> $stable(subLeft));

  p_side_toggle_r9: assert property (@(posedge clk) disable iff (!rstN)
    (subValid && subReady) |=> (subLeft != $past(subLeft)));

  p_underrun_silent_r10: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> (subAudio == 24'h0 && !subV && !wordValid));

  p_packed_left_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (packEn && sampleMode == 2'b00 && subLeft) |-> !wordReady);

  p_parity_even_r8: assert property (@(posedge clk) disable iff (!rstN)
    (subValid && (sampleMode != 2'b11 || !wordValid)) |-> !(^{subAudio, subV, subU, subC, subP}));

  p_valid_held_r1: assert property (@(posedge clk) disable iff (!rstN)
    subValid |=> subValid);
endmodule

bind spdif_txfmt spdif_txfmt_chk u_chk (.*);

// File: tb/spdif_txfmt_tb.sv
module spdif_txfmt_tb;
  localparam int CLK_PERIOD = 10;
  localparam int FR = 4;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  sampleMode = 2'b00;
  logic        packEn = 1'b0, usrBit = 1'b0, chanBit = 1'b0;
  logic        wordValid = 1'b0, subReady = 1'b0;
  logic [31:0] wordData = 32'h0;
  logic        wordReady, subValid, subV, subU, subC, subP, subLeft, underrun;
  logic [23:0] subAudio;
  logic [3:0]  subPreamble;

  int vecs = 0, errs = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spdif_txfmt #(.FRAMES_PER_BLOCK(FR)) u_dut (.*);

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // bench model state
  bit       mLeft = 1;
  int       mFrame = 0;
  bit       firstSub = 1;
  logic [31:0] curWord = 32'h0;
  int       wordIdx = 0;

  function automatic logic [31:0] mkWord(int idx);
    return (idx * 32'h9E3779B1) ^ (idx * 32'h0001_0F03) ^ 32'h5A5A_3C3C;
  endfunction

  task automatic step(int mode, bit pk, bit u, bit c, bit wv, bit rdy);
    bit pkAct;
    logic [23:0] eAud;
    logic eV, eU, eC, eP, eWr, eUr;
    logic [3:0] ePre, gPre;
    string aTag, hTag;
    @(negedge clk);
    sampleMode = 2'(mode); packEn = pk; usrBit = u; chanBit = c;
    wordValid = wv; subReady = rdy; wordData = curWord;
    #1;
    pkAct = pk && (mode == 0);
    gPre = (mLeft && mFrame == 0) ? 4'b0001 : (mLeft ? 4'b0010 : 4'b0100);
    if (!wv) begin
      eAud = 24'h0; aTag = "R10";
    end else if (mode == 0) begin
      eAud = (pkAct && !mLeft) ? 24'((curWord >> 16) * 256) : 24'((curWord & 32'hFFFF) * 256);
      aTag = pkAct ? "R6" : "R2";
    end else if (mode == 1) begin
      eAud = 24'((curWord & 32'hFFFFF) * 16); aTag = "R3";
    end else if (mode == 2) begin
      eAud = 24'(curWord % 32'h0100_0000); aTag = "R4";
    end else begin
      eAud = 24'((curWord / 16) % 32'h0100_0000); aTag = "R5";
    end
    if (wv && mode == 3) begin
      eP = curWord[31]; eC = curWord[30]; eU = curWord[29]; eV = curWord[28];
      ePre = curWord[3:0];
    end else begin
      eV = 0; eU = u; eC = c; ePre = gPre;
      eP = ($countones(eAud) + int'(u) + int'(c)) % 2 == 1;
    end
    eWr = rdy && !(pkAct && mLeft);
    eUr = rdy && !wv;
    hTag = !rdy ? "R11" : (!wv ? "R10" : (pkAct ? "R6" : (pk ? "R7" : "R2")));

    chk("R1", "subValid", 32'(subValid), 32'd1);
    chk(aTag, "audio", 32'(subAudio), 32'(eAud));
    chk((wv && mode == 3) ? "R5" : "R8", "VUCP", {28'h0, subV, subU, subC, subP}, {28'h0, eV, eU, eC, eP});
    chk(firstSub ? "R1" : ((wv && mode == 3) ? "R5" : "R9"), "preamble/side",
        {27'h0, subLeft, subPreamble}, {27'h0, mLeft, ePre});
    chk(hTag, "wordReady/underrun", {30'h0, wordReady, underrun}, {30'h0, eWr, eUr});

    if (rdy) begin
      firstSub = 0;
      if (wv && eWr) begin
        wordIdx++;
        curWord = mkWord(wordIdx);
      end
      if (!mLeft) mFrame = (mFrame + 1) % FR;
      mLeft = !mLeft;
    end
  endtask

  initial begin
    subReady = 1'b1; wordValid = 1'b1;
    curWord = mkWord(0);
    repeat (3) begin
      @(negedge clk); #1;
      chk("R1", "reset outputs", {29'h0, subValid, wordReady, underrun}, 32'h0);
    end
    @(negedge clk) rstN = 1'b1;
    @(posedge clk);
    for (int mode = 0; mode < 4; mode++) begin
      for (int pk = 0; pk < 2; pk++) begin
        for (int k = 0; k < 40; k++) begin
          step(mode, pk[0], k[0], k[1], (k % 7) != 5 && (k % 11) != 4, (k % 5) != 3);
        end
      end
    end
    // packed: underrun on left half, word arrives for right half
    for (int k = 0; k < 16; k++) begin
      step(0, 1'b1, k[1], k[2], (k % 3) != 0, 1'b1);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end
endmodule